// File: doc/BRIEF.md
# Ethernet Transmit Frame Builder

This block turns a host-side byte stream into a complete Ethernet frame for a MII-style serializer. The host supplies the destination address, source address, two-byte length/type and payload as one byte stream with an end marker. The block adds a synchronization preamble ahead of the frame. It extends short frames with zero bytes so they reach the minimum size, and it appends a CRC-32 frame check sequence.

Three per-frame controls are sampled when a frame begins. One drops the preamble, one drops the check sequence, and one disables padding. A programmable defer count sets the silent interval that follows every frame. A frame whose payload is too long is cut at the maximum size, and the rest of its input is drained and discarded. The frame's last output byte then carries an error flag.

Top module: `eth_tx_framer`

## Requirements
- R1: Unless `cfg_no_pre` was set at frame start, every frame begins with seven 0x55 bytes and then one 0xD5 byte. With `cfg_no_pre` set, the first output byte is the first input byte.
- R2: After the preamble, the input bytes come out in order and unchanged, counting from the first destination-address byte.
- R3: With padding enabled (`cfg_no_pad` low), a frame whose address, length and payload bytes total fewer than 60 is followed by 0x00 bytes until that count reaches 60. With padding disabled, no pad byte is added.
- R4: Unless `cfg_no_fcs` was set, four check bytes follow the body. They are the complement of a CRC-32 with polynomial 0x04C11DB7, initial value 0xFFFFFFFF and reflected bit order, computed over the body and pad bytes. They are sent least-significant byte first. `out_last` marks the final output byte of each frame.
- R5: A frame with more than 1500 payload bytes keeps only its first 1514 body bytes. The remaining input is accepted and dropped, and `out_err` is high together with `out_last` for that frame.
- R6: `out_err` stays low for frames whose payload is 1500 bytes or fewer.
- R7: When the next frame is already waiting, exactly `defer_gap + 2` cycles with `out_valid` low separate the `out_last` byte from the next frame's first byte.
- R8: The three per-frame controls are taken when the frame starts. Changing them during the frame has no effect on it.
- R9: During and right after reset, `out_valid` and `in_ready` are low.
- R10: If `in_valid` drops in the middle of a frame, output stalls, and the frame later resumes with no byte lost, repeated or reordered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Host byte present |
| in_data | input | 8 | Host byte |
| in_last | input | 1 | Host byte ends the frame |
| in_ready | output | 1 | Host byte accepted this cycle when valid |
| cfg_no_pre | input | 1 | Omit preamble for this frame |
| cfg_no_fcs | input | 1 | Omit check sequence for this frame |
| cfg_no_pad | input | 1 | Disable padding for this frame |
| defer_gap | input | DEFER_W | Extra idle cycles after each frame |
| out_valid | output | 1 | Output byte present |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Final byte of the frame |
| out_err | output | 1 | Frame was truncated (with out_last) |

## Verification
The bench sweeps payload lengths across the padding boundary in every control combination. A design with an off-by-one pad limit emits 59 or 61 body bytes there. A design that pads frames with padding disabled changes their length. The check bytes are compared against a serial CRC written independently. That comparison exposes a wrong byte order or a CRC that wrongly covers the preamble. Payloads of exactly 1500 and 1501 bytes show whether truncation starts one byte early or late, and whether leftover input leaks into the next frame. Measured idle gaps, controls flipped during a frame, and source stalls catch a miscounted defer timer, controls read live instead of latched, and bytes dropped on a stall.

// File: rtl/eth_tx_pkg.sv
package eth_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PRE, ST_DATA, ST_DRAIN, ST_PAD, ST_FCS, ST_GAP
  } tx_state_e;

  typedef struct packed {
    logic no_pre;
    logic no_fcs;
    logic no_pad;
  } tx_ctl_t;

  localparam logic [31:0] CRC_POLY = 32'h04C11DB7;
  localparam logic [7:0]  PRE_FILL = 8'h55;
  localparam logic [7:0]  PRE_SFD  = 8'hD5;

  function automatic logic [31:0] bit_rev32(input logic [31:0] v);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = v[31-i];
    return r;
  endfunction

  // One byte through the reflected CRC-32 register, data LSB first.
  function automatic logic [31:0] crc32_byte(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    logic [31:0] pr;
    logic fb;
    r  = c;
    pr = bit_rev32(CRC_POLY);
    for (int i = 0; i < 8; i++) begin
      fb = r[0] ^ d[i];
      r  = (r >> 1) ^ (fb ? pr : 32'h0);
    end
    return r;
  endfunction

  // Byte k of the transmitted check sequence (complemented, LSB byte first).
  function automatic logic [7:0] fcs_byte(input logic [31:0] c, input int k);
    logic [31:0] f;
    f = ~c;
    return f[8*k +: 8];
  endfunction

endpackage

// File: rtl/eth_tx_crc.sv
module eth_tx_crc
  import eth_tx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [31:0] crc_q
);
  always_ff @(posedge clk) begin
    if (!rst_n || clr) crc_q <= '1;
    else if (en)       crc_q <= crc32_byte(crc_q, din);
  end
endmodule

// File: rtl/eth_tx_defer.sv
module eth_tx_defer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         done
);
  logic [W-1:0] cnt;
  assign done = (cnt == '0);
  always_ff @(posedge clk) begin
    if (!rst_n)     cnt <= '0;
    else if (load)  cnt <= val;
    else if (!done) cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/eth_tx_framer.sv
module eth_tx_framer
  import eth_tx_pkg::*;
#(
  parameter int DEFER_W     = 8,
  parameter int ADDR_BYTES  = 6,
  parameter int LEN_BYTES   = 2,
  parameter int MAX_PAYLOAD = 1500,
  parameter int MIN_FRAME   = 64,
  parameter int PRE_BYTES   = 8,
  parameter int FCS_BYTES   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [7:0]         in_data,
  input  logic               in_last,
  output logic               in_ready,
  input  logic               cfg_no_pre,
  input  logic               cfg_no_fcs,
  input  logic               cfg_no_pad,
  input  logic [DEFER_W-1:0] defer_gap,
  output logic               out_valid,
  output logic [7:0]         out_data,
  output logic               out_last,
  output logic               out_err
);
  localparam int HDR_BYTES = 2*ADDR_BYTES + LEN_BYTES;
  localparam int BODY_MAX  = HDR_BYTES + MAX_PAYLOAD;
  localparam int PAD_TO    = MIN_FRAME - FCS_BYTES;
  localparam int CNT_W     = $clog2(BODY_MAX + 1);
  localparam int IDX_N     = (PRE_BYTES > FCS_BYTES) ? PRE_BYTES : FCS_BYTES;
  localparam int IDX_W     = $clog2(IDX_N + 1);

  tx_state_e        state, state_d;
  tx_ctl_t          ctl_q;
  logic [CNT_W-1:0] frm_cnt;
  logic [IDX_W-1:0] idx;
  logic             err_q;
  logic [31:0]      crc_q;

  // Named internal events
  logic start_ev, take_ev, at_limit, trunc_ev, need_pad;
  logic pad_end_ev, fcs_end_ev, gap_load, gap_done, crc_en;

  assign in_ready   = (state == ST_DATA) || (state == ST_DRAIN);
  assign take_ev    = in_valid && in_ready;
  assign start_ev   = (state == ST_IDLE) && in_valid;
  assign at_limit   = (frm_cnt == CNT_W'(BODY_MAX - 1));
  assign trunc_ev   = (state == ST_DATA) && take_ev && !in_last && at_limit;
  assign need_pad   = !ctl_q.no_pad && (frm_cnt < CNT_W'(PAD_TO - 1));
  assign pad_end_ev = (state == ST_PAD) && (frm_cnt == CNT_W'(PAD_TO - 1));
  assign fcs_end_ev = (state == ST_FCS) && (idx == IDX_W'(FCS_BYTES - 1));
  assign gap_load   = (state_d == ST_GAP) && (state != ST_GAP);
  assign crc_en     = ((state == ST_DATA) && take_ev) || (state == ST_PAD);

  eth_tx_crc u_crc (
    .clk(clk), .rst_n(rst_n), .clr(start_ev), .en(crc_en),
    .din((state == ST_PAD) ? 8'h00 : in_data), .crc_q(crc_q)
  );

  eth_tx_defer #(.W(DEFER_W)) u_defer (
    .clk(clk), .rst_n(rst_n), .load(gap_load), .val(defer_gap), .done(gap_done)
  );

  always_comb begin
    state_d = state;
    unique case (state)
      ST_IDLE:  if (in_valid) state_d = cfg_no_pre ? ST_DATA : ST_PRE;
      ST_PRE:   if (idx == IDX_W'(PRE_BYTES - 1)) state_d = ST_DATA;
      ST_DATA:  if (take_ev) begin
                  if (trunc_ev)     state_d = ST_DRAIN;
                  else if (in_last) state_d = need_pad ? ST_PAD :
                                              (ctl_q.no_fcs ? ST_GAP : ST_FCS);
                end
      ST_DRAIN: if (take_ev && in_last) state_d = ctl_q.no_fcs ? ST_GAP : ST_FCS;
      ST_PAD:   if (pad_end_ev) state_d = ctl_q.no_fcs ? ST_GAP : ST_FCS;
      ST_FCS:   if (fcs_end_ev) state_d = ST_GAP;
      ST_GAP:   if (gap_done) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      ctl_q     <= '0;
      frm_cnt   <= '0;
      idx       <= '0;
      err_q     <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= 8'h00;
      out_last  <= 1'b0;
      out_err   <= 1'b0;
    end else begin
      state     <= state_d;
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      out_err   <= 1'b0;
      unique case (state)
        ST_IDLE: if (start_ev) begin
          ctl_q   <= '{no_pre: cfg_no_pre, no_fcs: cfg_no_fcs, no_pad: cfg_no_pad};
          frm_cnt <= '0;
          idx     <= '0;
          err_q   <= 1'b0;
        end
        ST_PRE: begin
          out_valid <= 1'b1;
          out_data  <= (idx == IDX_W'(PRE_BYTES - 1)) ? PRE_SFD : PRE_FILL;
          idx       <= (state_d != ST_PRE) ? '0 : idx + 1'b1;
        end
        ST_DATA: if (take_ev) begin
          out_valid <= 1'b1;
          out_data  <= in_data;
          frm_cnt   <= frm_cnt + 1'b1;
          if (trunc_ev) err_q <= 1'b1;
          out_last  <= (state_d == ST_GAP) || (trunc_ev && ctl_q.no_fcs);
          out_err   <= trunc_ev && ctl_q.no_fcs;
        end
        ST_PAD: begin
          out_valid <= 1'b1;
          out_data  <= 8'h00;
          frm_cnt   <= frm_cnt + 1'b1;
          out_last  <= (state_d == ST_GAP);
        end
        ST_FCS: begin
          out_valid <= 1'b1;
          out_data  <= fcs_byte(crc_q, int'(idx));
          idx       <= idx + 1'b1;
          out_last  <= fcs_end_ev;
          out_err   <= fcs_end_ev && err_q;
        end
        default: ;
      endcase
    end
  end

  // Assertions
  AST_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);                                                  // R4
  AST_ERR_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    out_err |-> out_last);                                                    // R5
  AST_BODY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (frm_cnt <= CNT_W'(BODY_MAX)));                             // R5
  AST_PAD_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (out_last && !ctl_q.no_pad) |-> (frm_cnt >= CNT_W'(PAD_TO)));             // R3
  AST_GAP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_GAP && $past(state == ST_GAP)) |-> !out_valid);              // R7
  AST_FCS_CRC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FCS && $past(state == ST_FCS)) |-> $stable(crc_q));          // R4
  AST_CTL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE && $past(state != ST_IDLE)) |-> $stable(ctl_q));        // R8

endmodule

// File: tb/tb_eth_tx_framer.sv
module tb_eth_tx_framer;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0, in_ready;
  logic [7:0] in_data = 8'h00;
  logic cfg_no_pre = 1'b0, cfg_no_fcs = 1'b0, cfg_no_pad = 1'b0;
  logic [DW-1:0] defer_gap = '0;
  logic out_valid, out_last, out_err;
  logic [7:0] out_data;

  always #2 clk = ~clk;  // 250 MHz

  eth_tx_framer #(.DEFER_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .in_ready(in_ready), .cfg_no_pre(cfg_no_pre),
    .cfg_no_fcs(cfg_no_fcs), .cfg_no_pad(cfg_no_pad), .defer_gap(defer_gap),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last), .out_err(out_err)
  );

  int checks = 0;
  int errors = 0;

  int exp_b[$];
  int exp_r[$];
  int exp_len[$];
  bit exp_err[$];
  int exp_gap[$];
  bit exp_stall[$];

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic string req_name(int r);
    case (r)
      1: return "R1";
      2: return "R2";
      3: return "R3";
      default: return "R4";
    endcase
  endfunction

  // Serial reflected CRC-32, restated independently of the design.
  function automatic logic [31:0] tb_crc(logic [31:0] c, logic [7:0] b);
    c = c ^ {24'h0, b};
    repeat (8) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    return c;
  endfunction

  // Output monitor
  int fcnt = 0, idle = 0, bad_req = 0, bad_act = 0, bad_exp = 0;
  bit cur_stall = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid) begin
        if (fcnt == 0) begin
          bad_req = 0;
          if (exp_gap.size() > 0) begin
            int g;
            g = exp_gap.pop_front();
            if (g >= 0) check(idle == g, "R7", "idle cycles between frames", idle, g);
          end
          cur_stall = (exp_stall.size() > 0) ? exp_stall.pop_front() : 1'b0;
        end
        if (exp_b.size() > 0) begin
          int eb, er;
          eb = exp_b.pop_front();
          er = exp_r.pop_front();
          if (bad_req == 0 && int'(out_data) != eb) begin
            bad_req = er; bad_act = out_data; bad_exp = eb;
          end
        end
        fcnt++;
        if (out_last) begin
          int el;
          bit ee;
          el = (exp_len.size() > 0) ? exp_len.pop_front() : -1;
          ee = (exp_err.size() > 0) ? exp_err.pop_front() : 1'b0;
          check(fcnt == el, "R3", "frame length", fcnt, el);
          while (fcnt < el && exp_b.size() > 0) begin
            void'(exp_b.pop_front()); void'(exp_r.pop_front()); fcnt++;
          end
          check(bad_req == 0, (bad_req == 0) ? "R2" : req_name(bad_req),
                "first mismatching byte", bad_act, bad_exp);
          if (cur_stall)
            check(bad_req == 0, "R10", "stalled frame content", bad_act, bad_exp);
          check(out_err == ee, ee ? "R5" : "R6", "error flag", out_err, ee);
          fcnt = 0;
          idle = 0;
        end
      end else idle++;
    end
  end

  // Build expectation and drive one frame
  task automatic run_frame(int plen, bit np, bit nf, bit npd, bit stall, bit flip, int gap);
    logic [7:0] body[$];
    int n, eb;
    logic [31:0] c;
    body = {};
    for (int k = 0; k < 6; k++) body.push_back(8'h10 + 8'(k));
    for (int k = 0; k < 6; k++) body.push_back(8'h20 + 8'(k));
    body.push_back(8'(plen >> 8));
    body.push_back(8'(plen));
    for (int k = 0; k < plen; k++) body.push_back(8'(k * 13 + plen + 1));
    n  = body.size();
    eb = (n > 1514) ? 1514 : n;
    exp_len.push_back((np ? 0 : 8) + ((!npd && eb < 60) ? 60 : eb) + (nf ? 0 : 4));
    if (!np) begin
      for (int k = 0; k < 7; k++) begin exp_b.push_back(8'h55); exp_r.push_back(1); end
      exp_b.push_back(8'hD5); exp_r.push_back(1);
    end
    c = 32'hFFFFFFFF;
    for (int k = 0; k < eb; k++) begin
      exp_b.push_back(body[k]); exp_r.push_back(2); c = tb_crc(c, body[k]);
    end
    if (!npd)
      for (int k = eb; k < 60; k++) begin
        exp_b.push_back(0); exp_r.push_back(3); c = tb_crc(c, 8'h00);
      end
    if (!nf) begin
      c = ~c;
      for (int k = 0; k < 4; k++) begin exp_b.push_back(int'(c[8*k +: 8])); exp_r.push_back(4); end
    end
    exp_err.push_back(plen > 1500);
    exp_gap.push_back(gap);
    exp_stall.push_back(stall);

    for (int i = 0; i < n; i++) begin
      if (stall && i > 0 && (i % 5) == 0) begin  // R10 source stall
        @(negedge clk); in_valid = 1'b0;
        @(posedge clk);
      end
      @(negedge clk);
      if (i == 0) begin cfg_no_pre = np; cfg_no_fcs = nf; cfg_no_pad = npd; end
      in_valid = 1'b1; in_data = body[i]; in_last = (i == n - 1);
      while (!in_ready) @(negedge clk);
      @(posedge clk);
      if (flip && i == 0) begin  // R8: controls change mid-frame
        #1; cfg_no_pre = !np; cfg_no_fcs = !nf; cfg_no_pad = !npd;
      end
    end
  endtask

  task automatic wait_idle();
    @(negedge clk); in_valid = 1'b0; in_last = 1'b0;
    while (exp_len.size() > 0) @(negedge clk);
    repeat (int'(defer_gap) + 8) @(negedge clk);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R9", "out_valid in reset", out_valid, 0);
        check(in_ready == 1'b0, "R9", "in_ready in reset", in_ready, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R9", "out_valid after reset", out_valid, 0);
        check(in_ready == 1'b0, "R9", "in_ready after reset", in_ready, 0);
        begin
          logic [31:0] c;
          string s;
          s = "123456789";
          c = 32'hFFFFFFFF;
          for (int k = 0; k < 9; k++) c = tb_crc(c, s[k]);
          check(~c == 32'hCBF43926, "R4", "bench CRC anchor", int'(~c), int'(32'hCBF43926));
        end

        // Sweep across the padding boundary, all control combinations, defer 0
        defer_gap = 0;
        for (int L = 0; L <= 50; L++) begin
          int combo;
          combo = L % 8;
          run_frame(L, combo[0], combo[1], combo[2], (L % 3) == 0, 1'b0, (L == 0) ? -1 : 2);
        end
        for (int combo = 0; combo < 8; combo++)
          run_frame(47 - combo, combo[0], combo[1], combo[2], 1'b0, 1'b0, 2);
        wait_idle();

        // Defer 5, mid-frame control flips
        defer_gap = 5;
        run_frame(46, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, -1);
        run_frame(45, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 7);
        run_frame(10, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 7);
        run_frame(20, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 7);
        run_frame(100, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 7);
        wait_idle();

        // Size limit: exactly maximum, one over, well over with and without check bytes
        defer_gap = 3;
        run_frame(1500, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, -1);
        run_frame(1501, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5);
        run_frame(1510, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 5);
        run_frame(1500, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, -1);
        run_frame(30, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5);
        wait_idle();
        check(exp_b.size() == 0, "R2", "leftover expected bytes", exp_b.size(), 0);
      end
      begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule